// File: doc/BRIEF.md
# Configuration Header Write Filter

This block holds the 256-byte configuration header of a single-function device and decides, byte by byte, what a configuration write is allowed to change. A write carries a start address, a size code and up to four data bytes. The block splits the write into byte lanes at consecutive addresses. Each lane then goes through an address-dependent filter that passes, masks, forces or drops the byte. Configuration reads assemble one, two or four stored bytes little-endian and have no side effects.

Two pulse outputs tell the surrounding logic when to remap a window. One fires when the I/O base register actually changes value. The other fires on any write to the expansion ROM base, provided the ROM exists. The block also gates expansion ROM memory reads. A read returns the ROM byte at the address folded to the ROM size while the ROM enable bit is set, and all ones while it is clear.

Top module: `cfg_hdr_filter`

## Requirements
- R1: Writes to addresses 0x10 to 0x1F and 0x24 to 0x2F leave those bytes unchanged.
- R2: At address 0x04 only bit 0 (I/O enable) takes the written value. Bits 7:1 are stored as zero.
- R3: At address 0x20 the stored value is the written value with bits 1:0 forced to 01. Bytes 0x21 to 0x23 take the written value unchanged.
- R4: `io_base_changed` is high for exactly the one cycle after a write cycle in which at least one byte of 0x20 to 0x23 took a value different from its old value. It stays low otherwise, including when the same value is rewritten.
- R5: Byte 0x3C takes any written value.
- R6: With `ROM_PRESENT`=1, byte 0x30 keeps only bit 0 (ROM enable), byte 0x31 is masked with 0xFC, and bytes 0x32 and 0x33 take the written value. Any write touching 0x30 to 0x33 pulses `rom_base_changed` for one cycle, even if nothing changed. With `ROM_PRESENT`=0 these bytes are read-only and the pulse never occurs.
- R7: Every byte not named in R2, R3, R5 or R6 keeps its value when written. This includes the interrupt pin byte 0x3D.
- R8: After reset the header holds 0x04=0x01, 0x0D=0x20, 0x20..0x23=01 00 00 00, 0x3C=0x00, 0x3D=0x01, 0x6A=0x01 and 0xC1=0x20. Every other byte holds 0x00.
- R9: Size code 0 writes one byte, 1 writes two bytes, and 2 or 3 write four bytes. Data byte k goes to address start+k, modulo 256. All lanes of one write take effect together, one cycle after the write cycle.
- R10: A configuration read uses the same size code. It returns the byte at start+k (modulo 256) in data bits 8k+7:8k, with unused upper bytes zero. Reads change no state.
- R11: `rom_fetch_addr` is the ROM read address folded to the ROM size (its low `ROM_AW` bits). `rom_rd_data` is `rom_fetch_data` while bit 0 of byte 0x30 is set, and 0xFF while it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 8 | Write start address |
| cfg_wr_size | input | 2 | Write size code (0:1, 1:2, 2/3:4 bytes) |
| cfg_wr_data | input | 32 | Write data, byte k at bits 8k+7:8k |
| cfg_rd_addr | input | 8 | Read start address |
| cfg_rd_size | input | 2 | Read size code |
| cfg_rd_data | output | 32 | Little-endian read data |
| io_base_changed | output | 1 | One-cycle pulse: I/O base value changed |
| rom_base_changed | output | 1 | One-cycle pulse: ROM base written |
| rom_rd_addr | input | 32 | Expansion ROM memory read address |
| rom_fetch_addr | output | ROM_AW | Folded address to the ROM array |
| rom_fetch_data | input | 8 | Byte returned by the ROM array |
| rom_rd_data | output | 8 | Gated ROM read data |

## Verification
Filtered write results and both change pulses are due one clock after the write cycle. The bench drives a write on a falling edge, drops the strobe on the next falling edge, and samples the pulses and stored bytes there, so a pulse that lingers into a second cycle is caught by the following write's check. Configuration reads and the ROM path are combinational. Their address inputs are changed on a falling edge and the outputs are sampled 1 ns later. A sweep writes all ones and then all zeros to every one of the 256 addresses, on a ROM-equipped instance and a ROM-less one side by side.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    localparam int HDR_BYTES = 256;
    localparam int LANES     = 4;
    localparam int AW        = $clog2(HDR_BYTES);

    localparam logic [AW-1:0] A_CMD     = 8'h04;
    localparam logic [AW-1:0] A_IOBAR   = 8'h20;
    localparam logic [AW-1:0] A_ROMBAR  = 8'h30;
    localparam logic [AW-1:0] A_IRQLINE = 8'h3C;

    typedef enum logic [1:0] {
        SZ_B1  = 2'd0,
        SZ_B2  = 2'd1,
        SZ_B4  = 2'd2,
        SZ_B4X = 2'd3
    } xfer_size_e;

    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
        logic [7:0]    data;
    } lane_t;

    typedef struct packed {
        logic [7:0] value;
        logic       io_hit;
        logic       rom_hit;
    } lane_res_t;

    function automatic int unsigned size_bytes(xfer_size_e s);
        case (s)
            SZ_B1:   return 1;
            SZ_B2:   return 2;
            default: return 4;
        endcase
    endfunction

    function automatic logic [7:0] reset_value(logic [AW-1:0] a);
        case (a)
            8'h04, 8'h20, 8'h3D, 8'h6A: return 8'h01;
            8'h0D, 8'hC1:               return 8'h20;
            default:                    return 8'h00;
        endcase
    endfunction

    function automatic lane_res_t filter_lane(logic [AW-1:0] a, logic [7:0] nv,
                                              logic [7:0] ov, logic rom_present);
        lane_res_t r;
        r.value   = ov;
        r.io_hit  = 1'b0;
        r.rom_hit = 1'b0;
        case (a) inside
            A_CMD:     r.value = {7'b0, nv[0]};
            A_IRQLINE: r.value = nv;
            A_IOBAR: begin
                r.value  = {nv[7:2], 2'b01};
                r.io_hit = (r.value != ov);
            end
            [8'h21:8'h23]: begin
                r.value  = nv;
                r.io_hit = (nv != ov);
            end
            [8'h30:8'h33]: begin
                if (rom_present) begin
                    case (a[1:0])
                        2'd0:    r.value = {7'b0, nv[0]};
                        2'd1:    r.value = nv & 8'hFC;
                        default: r.value = nv;
                    endcase
                    r.rom_hit = 1'b1;
                end
            end
            default: r.value = ov;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cfg_lane_split.sv
module cfg_lane_split
    import cfg_hdr_pkg::*;
(
    input  logic                        wr_en,
    input  logic [AW-1:0]               wr_addr,
    input  logic [1:0]                  wr_size,
    input  logic [8*LANES-1:0]          wr_data,
    output lane_t [LANES-1:0]           lanes
);
    int unsigned nbytes;
    assign nbytes = size_bytes(xfer_size_e'(wr_size));

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lanes[k].en   = wr_en && (k < nbytes);
        assign lanes[k].addr = AW'(wr_addr + AW'(k));
        assign lanes[k].data = wr_data[8*k +: 8];
    end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_hdr_pkg::*;
#(
    parameter bit ROM_PRESENT = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  lane_t [LANES-1:0]   lanes,
    input  logic [AW-1:0]       rd_addr,
    input  logic [1:0]          rd_size,
    output logic [8*LANES-1:0]  rd_data,
    output logic                io_chg,
    output logic                rom_chg,
    output logic                rom_en
);
    logic [7:0]          mem [HDR_BYTES];
    lane_res_t           res [LANES];
    logic [LANES-1:0]    io_hits;
    logic [LANES-1:0]    rom_hits;
    logic [LANES-1:0]    lane_en;
    int unsigned         rd_n;

    for (genvar k = 0; k < LANES; k++) begin : g_filter
        always_comb begin
            res[k] = filter_lane(lanes[k].addr, lanes[k].data,
                                 mem[lanes[k].addr], ROM_PRESENT);
        end
        assign lane_en[k]  = lanes[k].en;
        assign io_hits[k]  = lanes[k].en && res[k].io_hit;
        assign rom_hits[k] = lanes[k].en && res[k].rom_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < HDR_BYTES; a++) begin
                mem[a] <= reset_value(AW'(a));
            end
            io_chg  <= 1'b0;
            rom_chg <= 1'b0;
        end else begin
            for (int k = 0; k < LANES; k++) begin
                if (lanes[k].en) begin
                    mem[lanes[k].addr] <= res[k].value;
                end
            end
            io_chg  <= |io_hits;
            rom_chg <= |rom_hits;
        end
    end

    assign rd_n = size_bytes(xfer_size_e'(rd_size));

    for (genvar k = 0; k < LANES; k++) begin : g_read
        assign rd_data[8*k +: 8] = (k < rd_n) ? mem[AW'(rd_addr + AW'(k))] : 8'h00;
    end

    assign rom_en = mem[A_ROMBAR][0];

    assert_cmd_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        |lane_en |=> (mem[A_CMD][7:1] == 7'b0));
    assert_iobar_type_R3: assert property (@(posedge clk) disable iff (rst)
        |lane_en |=> (mem[A_IOBAR][1:0] == 2'b01));
    assert_hole_stable_R1: assert property (@(posedge clk) disable iff (rst)
        |lane_en |=> ($stable(mem[8'h18]) && $stable(mem[8'h2C])));
    assert_pin_fixed_R7: assert property (@(posedge clk) disable iff (rst)
        |lane_en |=> $stable(mem[8'h3D]));
    assert_io_pulse_cause_R4: assert property (@(posedge clk) disable iff (rst)
        io_chg |-> $past(|lane_en));
    assert_rom_pulse_cause_R6: assert property (@(posedge clk) disable iff (rst)
        rom_chg |-> ($past(|lane_en) && ROM_PRESENT));
endmodule

// File: rtl/cfg_rom_gate.sv
module cfg_rom_gate #(
    parameter int ROM_AW = 11
) (
    input  logic              rom_en,
    input  logic [31:0]       rd_addr,
    output logic [ROM_AW-1:0] fetch_addr,
    input  logic [7:0]        fetch_data,
    output logic [7:0]        rd_data
);
    logic unused_hi;
    assign unused_hi  = ^rd_addr[31:ROM_AW];
    assign fetch_addr = rd_addr[ROM_AW-1:0];
    assign rd_data    = rom_en ? fetch_data : 8'hFF;
endmodule

// File: rtl/cfg_hdr_filter.sv
module cfg_hdr_filter
    import cfg_hdr_pkg::*;
#(
    parameter bit ROM_PRESENT = 1'b1,
    parameter int ROM_AW      = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [7:0]        cfg_wr_addr,
    input  logic [1:0]        cfg_wr_size,
    input  logic [31:0]       cfg_wr_data,
    input  logic [7:0]        cfg_rd_addr,
    input  logic [1:0]        cfg_rd_size,
    output logic [31:0]       cfg_rd_data,
    output logic              io_base_changed,
    output logic              rom_base_changed,
    input  logic [31:0]       rom_rd_addr,
    output logic [ROM_AW-1:0] rom_fetch_addr,
    input  logic [7:0]        rom_fetch_data,
    output logic [7:0]        rom_rd_data
);
    lane_t [LANES-1:0] lanes;
    logic              rom_en;

    cfg_lane_split u_split (
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_wr_addr),
        .wr_size (cfg_wr_size),
        .wr_data (cfg_wr_data),
        .lanes   (lanes)
    );

    cfg_regfile #(.ROM_PRESENT(ROM_PRESENT)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .lanes   (lanes),
        .rd_addr (cfg_rd_addr),
        .rd_size (cfg_rd_size),
        .rd_data (cfg_rd_data),
        .io_chg  (io_base_changed),
        .rom_chg (rom_base_changed),
        .rom_en  (rom_en)
    );

    cfg_rom_gate #(.ROM_AW(ROM_AW)) u_rom (
        .rom_en     (rom_en),
        .rd_addr    (rom_rd_addr),
        .fetch_addr (rom_fetch_addr),
        .fetch_data (rom_fetch_data),
        .rd_data    (rom_rd_data)
    );

    assert_pulses_single_R4: assert property (@(posedge clk) disable iff (rst)
        io_base_changed |=> !io_base_changed || $past(cfg_wr_en));
endmodule

// File: tb/cfg_hdr_filter_test.sv
module cfg_hdr_filter_test;
    localparam int RAW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_addr = '0;
    logic [1:0]  cfg_wr_size = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [7:0]  cfg_rd_addr = '0;
    logic [1:0]  cfg_rd_size = '0;
    logic [31:0] rom_rd_addr = '0;
    logic [31:0] rdata_p, rdata_a;
    logic        io_p, rom_p, io_a, rom_a;
    logic [RAW-1:0] fa_p, fa_a;
    logic [7:0]  fd_p, rd_p, rd_a;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [7:0] exp_p [256];
    logic [7:0] exp_a [256];

    always #10 clk = ~clk;

    assign fd_p = {fa_p, ~fa_p} ^ 8'h3C;

    cfg_hdr_filter #(.ROM_PRESENT(1'b1), .ROM_AW(RAW)) uut (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
        .cfg_wr_size(cfg_wr_size), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_addr(cfg_rd_addr), .cfg_rd_size(cfg_rd_size), .cfg_rd_data(rdata_p),
        .io_base_changed(io_p), .rom_base_changed(rom_p), .rom_rd_addr(rom_rd_addr),
        .rom_fetch_addr(fa_p), .rom_fetch_data(fd_p), .rom_rd_data(rd_p));

    cfg_hdr_filter #(.ROM_PRESENT(1'b0), .ROM_AW(RAW)) uut_norom (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
        .cfg_wr_size(cfg_wr_size), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_addr(cfg_rd_addr), .cfg_rd_size(cfg_rd_size), .cfg_rd_data(rdata_a),
        .io_base_changed(io_a), .rom_base_changed(rom_a), .rom_rd_addr(rom_rd_addr),
        .rom_fetch_addr(fa_a), .rom_fetch_data(8'h00), .rom_rd_data(rd_a));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R8 defaults as listed in the requirement
    function automatic logic [7:0] dflt(int a);
        if (a == 'h04 || a == 'h20 || a == 'h3D || a == 'h6A) return 8'h01;
        if (a == 'h0D || a == 'hC1) return 8'h20;
        return 8'h00;
    endfunction

    function automatic string tag_of(int a);
        if ((a >= 'h10 && a <= 'h1F) || (a >= 'h24 && a <= 'h2F)) return "R1";
        if (a == 'h04) return "R2";
        if (a >= 'h20 && a <= 'h23) return "R3";
        if (a == 'h3C) return "R5";
        if (a >= 'h30 && a <= 'h33) return "R6";
        return "R7";
    endfunction

    // Expected new value of one byte per R1..R7; sets change flags
    function automatic logic [7:0] rule(int a, logic [7:0] nv, logic [7:0] ov,
                                       bit rom, inout bit io_f, inout bit rom_f);
        logic [7:0] v;
        v = ov;
        if (a == 'h04) v = nv & 8'h01;
        else if (a == 'h3C) v = nv;
        else if (a >= 'h20 && a <= 'h23) begin
            v = (a == 'h20) ? ((nv & 8'hFC) + 8'h01) : nv;
            if (v != ov) io_f = 1;
        end else if (rom && a >= 'h30 && a <= 'h33) begin
            if (a == 'h30) v = nv % 2;
            else if (a == 'h31) v = nv & 8'hFC;
            else v = nv;
            rom_f = 1;
        end
        return v;
    endfunction

    task automatic do_write(input int a, input int sz, input logic [31:0] d);
        bit iop = 0, romp = 0, ioa = 0, roma = 0;
        int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        for (int k = 0; k < n; k++) begin
            int ad = (a + k) % 256;
            logic [7:0] b = d[8*k +: 8];
            exp_p[ad] = rule(ad, b, exp_p[ad], 1, iop, romp);
            exp_a[ad] = rule(ad, b, exp_a[ad], 0, ioa, roma);
        end
        @(negedge clk);
        cfg_wr_en = 1; cfg_wr_addr = 8'(a); cfg_wr_size = 2'(sz); cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 0;
        check("R4 io_base_changed", {31'b0, io_p}, {31'b0, iop});
        check("R4 io_base_changed no-rom", {31'b0, io_a}, {31'b0, ioa});
        check("R6 rom_base_changed", {31'b0, rom_p}, {31'b0, romp});
        check("R6 rom_base_changed no-rom", {31'b0, rom_a}, 32'h0);
    endtask

    task automatic rd_check(input string req, input int a, input int sz);
        logic [31:0] ep = '0, ea = '0;
        int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        for (int k = 0; k < n; k++) begin
            ep[8*k +: 8] = exp_p[(a + k) % 256];
            ea[8*k +: 8] = exp_a[(a + k) % 256];
        end
        cfg_rd_addr = 8'(a); cfg_rd_size = 2'(sz);
        #1;
        check(req, rdata_p, ep);
        check({req, " no-rom"}, rdata_a, ea);
    endtask

    task automatic rom_sweep(input bit en);
        for (int r = 0; r < 40; r++) begin
            logic [31:0] ad = 32'(r * 37 + 'h5000);
            logic [RAW-1:0] f = ad[RAW-1:0];
            @(negedge clk);
            rom_rd_addr = ad;
            #1;
            check("R11 fetch addr", {28'b0, fa_p}, {28'b0, f});
            check("R11 rom data", {24'b0, rd_p}, en ? {24'b0, {f, ~f} ^ 8'h3C} : 32'hFF);
            check("R11 no-rom data", {24'b0, rd_a}, 32'hFF);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 256; a++) begin
            exp_p[a] = dflt(a);
            exp_a[a] = dflt(a);
        end
        repeat (3) @(negedge clk);
        rst = 0;
        // R8: reset contents of every byte
        for (int a = 0; a < 256; a++) rd_check("R8 reset value", a, 0);
        check("R8 io pulse low", {31'b0, io_p}, 32'h0);
        check("R8 rom pulse low", {31'b0, rom_p}, 32'h0);
        // R11: ROM disabled after reset
        rom_sweep(0);
        // Sweep: all ones then all zeros at every address
        for (int a = 0; a < 256; a++) begin
            do_write(a, 0, 32'hFF);
            rd_check(tag_of(a), a, 0);
            do_write(a, 0, 32'h00);
            rd_check(tag_of(a), a, 0);
        end
        // R4: same value rewrite gives no pulse; R6: same value still pulses
        do_write('h22, 0, 32'h5A);
        do_write('h22, 0, 32'h5A);
        do_write('h32, 0, 32'h00);
        rd_check("R6 rom bar", 'h30, 2);
        // R9: multi-byte writes, including address wrap and the command byte
        do_write('h3A, 2, 32'h44332211);
        rd_check("R9 word at 3A", 'h3A, 2);
        do_write('h20, 1, 32'h0000ABCD);
        rd_check("R9 half at 20", 'h20, 3);
        do_write('hFE, 3, 32'hDEADBEEF);
        rd_check("R9 wrap write", 'hFE, 2);
        do_write('h02, 2, 32'h77FF5533);
        rd_check("R9 word at 02", 'h02, 2);
        do_write('h30, 2, 32'h12345678);
        rd_check("R9 rom word", 'h30, 2);
        // R10: read sizes, wrap, and no side effects from repeated reads
        for (int a = 0; a < 256; a += 13) begin
            rd_check("R10 read 2", a, 1);
            rd_check("R10 read 4", a, 2);
            rd_check("R10 read 4 again", a, 3);
        end
        rd_check("R10 wrap read", 'hFD, 2);
        // R11: enable ROM and sweep again
        do_write('h30, 0, 32'h01);
        rom_sweep(1);
        do_write('h30, 0, 32'hFE);
        rom_sweep(0);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule